// File: doc/BRIEF.md
# Depuncturing Soft Branch Metric Unit

This block sits at the front of a rate-1/2 convolutional decoder. It takes received code symbols one at a time, each a 3-bit soft value, and rebuilds the two-symbol codewords (first generator output G1, second generator output G2) of the mother code. When the link runs a punctured rate (2/3 or 3/4), the block knows which mother-code positions were dropped by the transmitter. It fills each of them with a neutral value that favours neither bit, so that a dropped symbol adds the same cost to every candidate.

For every rebuilt codeword the block emits four branch metrics, one per ideal codeword 00, 01, 10 and 11. These are the costs an add-compare-select stage adds to its path metrics. In soft mode each symbol's cost is a scaled squared distance taken from an 8-entry table. In hard mode each symbol is reduced to its sign bit and costs either nothing or the full scale. The puncture rate and the mode are sampled once per puncture group, so a change made in mid-group takes effect only at the next group boundary.

The depuncturing is a four-state machine that tracks the position inside the puncture group:
- `ST_A1`: waiting for G1 of the first codeword.
- `ST_A2`: waiting for G2 of the first codeword.
- `ST_B1`: waiting for G1 of a codeword whose G2 was dropped.
- `ST_C2`: waiting for G2 of a codeword whose G1 was dropped.

Each transition is taken only on an accepted symbol:
- `ST_A1` goes to `ST_A2`.
- `ST_A2` returns to `ST_A1` at rate 1/2, and goes to `ST_B1` at rate 2/3 or 3/4.
- `ST_B1` returns to `ST_A1` at rate 2/3, and goes to `ST_C2` at rate 3/4.
- `ST_C2` returns to `ST_A1`.

Every accepted symbol outside `ST_A1` completes exactly one codeword. The input therefore never needs to stall.

Top module: `dpbm_unit`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `out_valid` and `out_bm` are all 0. `in_ready` becomes 1 at the first rising clock edge with `rst_n` high, and then stays 1.
- R2: A soft symbol code c (0..7) stands for the sample 2c-7: code 0 is a confident 0 bit and code 7 a confident 1 bit. The soft cost of c against bit 0 is floor((c*c+3)/7), which gives 0,0,1,1,2,4,5,7 for c = 0..7. The soft cost of c against bit 1 is the cost of 7-c against bit 0.
- R3: With `rate_sel`=00, every two accepted symbols form one codeword: G1 first, then G2.
- R4: With `rate_sel`=01 (rate 2/3), each group of three accepted symbols s0 s1 s2 forms two codewords: (s0,s1), then (s2, punctured).
- R5: With `rate_sel`=10 (rate 3/4), each group of four accepted symbols s0..s3 forms three codewords: (s0,s1), then (s2, punctured), then (punctured, s3).
- R6: A punctured position costs 2 against both bit values in soft mode, and 0 against both in hard mode.
- R7: The metric for ideal codeword ab is the cost of G1 against bit a plus the cost of G2 against bit b. It is placed in `out_bm[4*(2a+b) +: 4]` and never exceeds 14.
- R8: With `hard_sel`=1, a received symbol counts as bit 1 when its MSB is 1, and as bit 0 otherwise. It costs 0 against a matching bit and 7 against the other bit.
- R9: `rate_sel` and `hard_sel` are sampled only when the first symbol of a group is accepted. Changes to them at any other time have no effect on the current group.
- R10: `out_valid` is high for exactly the one cycle after the clock edge that accepted a symbol completing a codeword. `out_bm` holds its last value at all other times.
- R11: A cycle in which `in_valid` is low consumes no symbol: neither the group position nor the outputs change, whatever `in_sym` carries.
- R12: `rate_sel`=11 behaves exactly like rate 1/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received symbol is present on `in_sym` |
| in_ready | output | 1 | The block accepts a symbol in this cycle |
| in_sym | input | 3 | Soft received symbol code |
| rate_sel | input | 2 | Puncture rate: 00 = 1/2, 01 = 2/3, 10 = 3/4, 11 = 1/2 |
| hard_sel | input | 1 | 1 selects hard-decision costs |
| out_valid | output | 1 | One-cycle pulse per rebuilt codeword |
| out_bm | output | 16 | Four 4-bit metrics for codewords 00, 01, 10, 11 (lowest field first) |

## Verification
The bench builds the block with its default widths: 3-bit symbols and 4-bit metrics. With these widths all eight soft levels can be reached by a long random run, and the largest metric, 14, sits one step below the 4-bit ceiling, so any carry loss in the adder is exposed. The reference model walks the mother-code positions of each puncture group, independently of the state machine, so every rate, every position a group can be cut at, and the rate changes made in mid-group are all compared on every clock.

// File: rtl/dpbm_pkg.sv
package dpbm_pkg;

    // Puncture rate codes on rate_sel
    localparam logic [1:0] RATE_12  = 2'b00;
    localparam logic [1:0] RATE_23  = 2'b01;
    localparam logic [1:0] RATE_34  = 2'b10;
    localparam logic [1:0] RATE_12B = 2'b11;

    // Position inside a puncture group, named by the next expected symbol
    typedef enum logic [1:0] {
        ST_A1 = 2'd0,
        ST_A2 = 2'd1,
        ST_B1 = 2'd2,
        ST_C2 = 2'd3
    } grp_state_e;

    localparam int CW_SYMS = 2;
    localparam int CW_CAND = 4;

endpackage

// File: rtl/dpbm_depunct.sv
module dpbm_depunct
    import dpbm_pkg::*;
#(
    parameter int SYM_W = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              accept,
    input  logic [SYM_W-1:0]                  in_sym,
    input  logic [1:0]                        rate_sel,
    input  logic                              hard_sel,
    output logic                              emit,
    output logic [CW_SYMS-1:0][SYM_W-1:0]     g_sym,
    output logic [CW_SYMS-1:0]                g_punct,
    output logic                              hard_lat,
    output logic [1:0]                        rate_lat,
    output grp_state_e                        cur_state
);

    grp_state_e       state_q, state_d;
    logic [SYM_W-1:0] g1_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_A1;
        end else begin
            state_q <= state_d;
        end
    end

    // Group-start capture of the first symbol and of the rate and mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g1_q     <= '0;
            rate_lat <= RATE_12;
            hard_lat <= 1'b0;
        end else if (accept && state_q == ST_A1) begin
            g1_q     <= in_sym;
            rate_lat <= rate_sel;
            hard_lat <= hard_sel;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_A1: if (accept) state_d = ST_A2;
            ST_A2: if (accept) begin
                state_d = (rate_lat == RATE_23 || rate_lat == RATE_34) ? ST_B1 : ST_A1;
            end
            ST_B1: if (accept) begin
                state_d = (rate_lat == RATE_34) ? ST_C2 : ST_A1;
            end
            ST_C2: if (accept) state_d = ST_A1;
        endcase
    end

    // Codeword assembly outputs
    always_comb begin
        emit    = 1'b0;
        g_sym   = '0;
        g_punct = '0;
        unique case (state_q)
            ST_A1: begin
                emit = 1'b0;
            end
            ST_A2: begin
                emit     = accept;
                g_sym[0] = g1_q;
                g_sym[1] = in_sym;
            end
            ST_B1: begin
                emit       = accept;
                g_sym[0]   = in_sym;
                g_punct[1] = 1'b1;
            end
            ST_C2: begin
                emit       = accept;
                g_punct[0] = 1'b1;
                g_sym[1]   = in_sym;
            end
        endcase
    end

    assign cur_state = state_q;

endmodule

// File: rtl/dpbm_sym_cost.sv
module dpbm_sym_cost #(
    parameter int SYM_W = 3,
    parameter int MET_W = 4
) (
    input  logic [SYM_W-1:0] sym,
    input  logic             punct,
    input  logic             hard,
    output logic [MET_W-1:0] cost0,
    output logic [MET_W-1:0] cost1
);

    localparam int LMAX       = (1 << SYM_W) - 1;
    localparam int HALF       = LMAX / 2;
    localparam int PUNCT_SOFT = ((LMAX * LMAX) / 4 + HALF) / LMAX;

    localparam logic [MET_W-1:0] FULL_COST   = MET_W'(LMAX);
    localparam logic [MET_W-1:0] PUNCT_COSTV = MET_W'(PUNCT_SOFT);

    // Scaled squared distance from the bit-0 extreme
    function automatic logic [MET_W-1:0] soft_cost(input logic [SYM_W-1:0] c);
        int v;
        v = int'(c);
        return MET_W'((v * v + HALF) / LMAX);
    endfunction

    always_comb begin
        if (punct) begin
            cost0 = hard ? '0 : PUNCT_COSTV;
            cost1 = hard ? '0 : PUNCT_COSTV;
        end else if (hard) begin
            cost0 = sym[SYM_W-1] ? FULL_COST : '0;
            cost1 = sym[SYM_W-1] ? '0 : FULL_COST;
        end else begin
            cost0 = soft_cost(sym);
            cost1 = soft_cost(~sym);
        end
    end

endmodule

// File: rtl/dpbm_metric_reg.sv
module dpbm_metric_reg
    import dpbm_pkg::*;
#(
    parameter int MET_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          emit,
    input  logic [CW_SYMS-1:0][MET_W-1:0] cost0,
    input  logic [CW_SYMS-1:0][MET_W-1:0] cost1,
    output logic                          out_valid,
    output logic [CW_CAND*MET_W-1:0]      out_bm
);

    logic [CW_CAND-1:0][MET_W-1:0] sum_d;

    for (genvar k = 0; k < CW_CAND; k++) begin : g_cand
        localparam int BIT_A = (k / 2) % 2;
        localparam int BIT_B = k % 2;
        logic [MET_W-1:0] part_a, part_b;
        assign part_a   = (BIT_A != 0) ? cost1[0] : cost0[0];
        assign part_b   = (BIT_B != 0) ? cost1[1] : cost0[1];
        assign sum_d[k] = part_a + part_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bm    <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_bm <= sum_d;
            end
        end
    end

endmodule

// File: rtl/dpbm_unit.sv
module dpbm_unit
    import dpbm_pkg::*;
#(
    parameter int SYM_W = 3,
    parameter int MET_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [SYM_W-1:0]         in_sym,
    input  logic [1:0]               rate_sel,
    input  logic                     hard_sel,
    output logic                     out_valid,
    output logic [CW_CAND*MET_W-1:0] out_bm
);

    logic                          rdy_q;
    logic                          accept;
    logic                          emit;
    logic [CW_SYMS-1:0][SYM_W-1:0] g_sym;
    logic [CW_SYMS-1:0]            g_punct;
    logic                          hard_lat;
    logic [1:0]                    rate_lat;
    grp_state_e                    cur_state;
    logic [CW_SYMS-1:0][MET_W-1:0] cost0, cost1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
        end else begin
            rdy_q <= 1'b1;
        end
    end

    assign in_ready = rdy_q;
    assign accept   = in_valid & rdy_q;

    dpbm_depunct #(.SYM_W(SYM_W)) u_depunct (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .in_sym    (in_sym),
        .rate_sel  (rate_sel),
        .hard_sel  (hard_sel),
        .emit      (emit),
        .g_sym     (g_sym),
        .g_punct   (g_punct),
        .hard_lat  (hard_lat),
        .rate_lat  (rate_lat),
        .cur_state (cur_state)
    );

    for (genvar i = 0; i < CW_SYMS; i++) begin : g_slot
        dpbm_sym_cost #(.SYM_W(SYM_W), .MET_W(MET_W)) u_cost (
            .sym   (g_sym[i]),
            .punct (g_punct[i]),
            .hard  (hard_lat),
            .cost0 (cost0[i]),
            .cost1 (cost1[i])
        );
    end

    dpbm_metric_reg #(.MET_W(MET_W)) u_metric (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (emit),
        .cost0     (cost0),
        .cost1     (cost1),
        .out_valid (out_valid),
        .out_bm    (out_bm)
    );

endmodule

// File: rtl/dpbm_chk.sv
module dpbm_chk
    import dpbm_pkg::*;
#(
    parameter int SYM_W = 3,
    parameter int MET_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     out_valid,
    input logic [CW_CAND*MET_W-1:0] out_bm,
    input logic                     hard_lat,
    input logic [1:0]               rate_lat,
    input grp_state_e               cur_state
);

    localparam int LMAX = (1 << SYM_W) - 1;

    logic all_in_range;
    logic some_zero;

    always_comb begin
        all_in_range = 1'b1;
        some_zero    = 1'b0;
        for (int k = 0; k < CW_CAND; k++) begin
            if (int'(out_bm[k*MET_W +: MET_W]) > 2 * LMAX) all_in_range = 1'b0;
            if (out_bm[k*MET_W +: MET_W] == '0) some_zero = 1'b1;
        end
    end

    AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready); // R1

    AST_VALID_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready)); // R10

    AST_BM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_bm)); // R10

    AST_BM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> all_in_range); // R7

    AST_HARD_ZERO_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hard_lat) |-> some_zero); // R8

    AST_DROP_G2_RATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_B1) |-> (rate_lat == RATE_23 || rate_lat == RATE_34)); // R4

    AST_DROP_G1_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_C2) |-> (rate_lat == RATE_34)); // R5

endmodule

bind dpbm_unit dpbm_chk #(.SYM_W(SYM_W), .MET_W(MET_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_bm    (out_bm),
    .hard_lat  (hard_lat),
    .rate_lat  (rate_lat),
    .cur_state (cur_state)
);

// File: tb/dpbm_unit_tb.sv
module dpbm_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_sym = '0;
    logic [1:0]  rate_sel = '0;
    logic        hard_sel = 1'b0;
    logic        out_valid;
    logic [15:0] out_bm;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state
    int          pos = 0;
    int          lat_rate = 0;
    bit          lat_hard = 0;
    int          cw_sym [2];
    bit          cw_p [2];
    bit          exp_valid = 0;
    logic [15:0] exp_bm = '0;
    int          ctab [8] = '{0, 0, 1, 1, 2, 4, 5, 7};

    always #4 clk = ~clk;

    dpbm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sym(in_sym), .rate_sel(rate_sel), .hard_sel(hard_sel),
        .out_valid(out_valid), .out_bm(out_bm)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int glen(input int r);
        if (r == 1) return 4;
        if (r == 2) return 6;
        return 2;
    endfunction

    function automatic bit kept(input int r, input int p);
        if (r == 1) return p != 3;
        if (r == 2) return !(p == 3 || p == 4);
        return 1;
    endfunction

    function automatic int cost(input int s, input bit p, input int b);
        if (p) return lat_hard ? 0 : 2;           // R6
        if (lat_hard) return ((s >> 2) == b) ? 0 : 7;  // R8
        return (b == 0) ? ctab[s] : ctab[7 - s];  // R2
    endfunction

    function automatic void place(input int s, input bit p);
        int slot;
        slot = pos % 2;
        cw_sym[slot] = s;
        cw_p[slot] = p;
        pos++;
        if (slot == 1) begin
            exp_valid = 1;
            for (int k = 0; k < 4; k++) begin
                exp_bm[4*k +: 4] = 4'(cost(cw_sym[0], cw_p[0], k >> 1) +
                                     cost(cw_sym[1], cw_p[1], k & 1)); // R7
            end
        end
    endfunction

    function automatic void model_accept(input int s);
        if (pos == 0) begin   // R9: sampled at group start only
            lat_rate = int'(rate_sel);
            lat_hard = hard_sel;
        end
        place(s, 0);
        while (pos < glen(lat_rate) && !kept(lat_rate, pos)) place(0, 1);
        if (pos >= glen(lat_rate)) pos = 0;
    endfunction

    task automatic step(input bit v, input int s, input int r, input bit h, input string tag);
        @(negedge clk);
        chk(in_ready === 1'b1, {tag, " R1 ready"}, in_ready, 1);
        chk(out_valid === exp_valid, {tag, " R10 valid"}, out_valid, exp_valid);
        chk(out_bm === exp_bm, {tag, " R7 metrics"}, out_bm, exp_bm);
        in_valid = v;
        in_sym   = 3'(s);
        rate_sel = 2'(r);
        hard_sel = h;
        exp_valid = 0;
        if (v && in_ready) model_accept(s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk(in_ready === 1'b0, "R1 ready in reset", in_ready, 0);
            chk(out_valid === 1'b0, "R1 valid in reset", out_valid, 0);
            chk(out_bm === 16'h0, "R1 metrics in reset", out_bm, 0);
        end
        rst_n = 1'b1;

        // R3: rate 1/2 soft, all levels
        for (int i = 0; i < 16; i++) step(1, i % 8, 0, 0, "R3");
        // R11: idle cycles with junk symbols
        for (int i = 0; i < 4; i++) step(0, 7 - i, 2, 1, "R11");
        step(1, 5, 0, 0, "R11");
        step(0, 1, 1, 1, "R11");
        step(1, 2, 0, 0, "R11");

        // R4: rate 2/3
        for (int i = 0; i < 12; i++) step(1, (i * 3) % 8, 1, 0, "R4");
        // R5: rate 3/4 with gaps
        for (int i = 0; i < 16; i++) step(i % 5 != 2, (i * 5 + 1) % 8, 2, 0, "R5");
        // R8: hard mode at rate 3/4 and 1/2
        for (int i = 0; i < 12; i++) step(1, (i * 7) % 8, 2, 1, "R8");
        for (int i = 0; i < 8; i++) step(1, i, 0, 1, "R8");
        // R12: code 11 as rate 1/2
        for (int i = 0; i < 8; i++) step(1, 7 - i, 3, 0, "R12");

        // R9: change rate and mode inside a group
        step(1, 6, 2, 0, "R9");
        step(1, 1, 0, 1, "R9");
        step(1, 3, 1, 1, "R9");
        step(1, 4, 0, 0, "R9");
        step(1, 0, 1, 1, "R9");
        step(1, 7, 2, 0, "R9");
        step(1, 2, 0, 0, "R9");

        // R2 R6: mixed random run
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) != 0, $urandom % 8, $urandom % 4, ($urandom % 3) == 0, "R2 R6");

        step(0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, "R10");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule